// File: doc/BRIEF.md
# Per-Channel Change Detection Unit

This block watches a 32-bit parallel input, arranged as four 8-bit ports, and raises an event when any channel shows a transition that its own configuration counts as significant. The input is sampled once per period of a sample clock. The sample clock is a level signal that is already synchronous to the core clock. Configuration chooses whether sampling happens on the rising or the falling edge of that signal. Each new sample is compared only with the sample before it. The detection resolution is therefore one sample period, and a pulse that appears and disappears between two samples is not seen.

Every channel has its own 2-bit mode. The mode selects whether the channel is ignored, or whether a rising transition, a falling transition, or either transition counts. When a sample contains at least one qualifying transition, the block does three things:
- It latches the sample itself.
- It latches a mask of the channels that qualified.
- It starts an event pulse whose width is counted in core clock cycles. This width is set independently of the sample period. At a 100 MHz core clock, for example, a setting of 5 gives 50 ns and a setting of 2 gives 20 ns.

A further qualifying sample that arrives while the pulse is high restarts the width count. The block is used as the detection stage in front of a pattern acquisition path. The sample clock generator and the data buffer lie outside it.

Top module: `change_watch`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears its state. After that edge, evt_pulse is 0, cap_data is 0 and cap_mask is 0.
- R2: A channel with mode 2'b01 (rising) qualifies only when its previous sample is 0 and its new sample is 1.
- R3: A channel with mode 2'b10 (falling) qualifies only when its previous sample is 1 and its new sample is 0.
- R4: A channel with mode 2'b11 (either edge) qualifies on any change between consecutive samples. A channel with mode 2'b00 (ignore) never qualifies. Channel i uses mode_cfg[2i+1:2i].
- R5: With smp_on_fall = 0, din is sampled at the core clock edge where smp_clk is first seen high after being low. With smp_on_fall = 1, it is sampled where smp_clk is first seen low after being high. A value of din that is present only between two sample points has no effect.
- R6: The first sample after reset, or after enable rises, only loads the previous-sample register and never produces an event.
- R7: A qualifying sample taken at core clock edge k makes evt_pulse high from edge k+1 for max(pulse_len, 1) core clock cycles.
- R8: A qualifying sample taken while evt_pulse is high restarts the count, so the pulse stays high for the full width measured from the new sample.
- R9: On each qualifying sample, cap_data takes the sampled din and cap_mask takes the set of qualifying channels. Both hold their values until the next qualifying sample.
- R10: While enable is low, no sample is taken, no new event starts, and cap_data and cap_mask keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Detection enable |
| smp_clk | input | 1 | Sample clock level, synchronous to clk |
| smp_on_fall | input | 1 | 0: sample on the rising edge of smp_clk; 1: sample on the falling edge |
| din | input | 32 | Monitored channels |
| mode_cfg | input | 64 | Per-channel mode, 2 bits per channel |
| pulse_len | input | 8 | Event pulse width in core clock cycles (0 acts as 1) |
| evt_pulse | output | 1 | Change event pulse |
| cap_data | output | 32 | Sample that caused the last event |
| cap_mask | output | 32 | Channels that qualified in that sample |

## Verification
A wrong previous-sample register or a stale valid flag shows up at the ports one core clock after the next sample point. Depending on the fault, evt_pulse either rises when it should not or stays low when it should rise, and cap_mask disagrees with the modelled set of qualifying channels. A faulty pulse counter shows as a pulse that is one or more cycles too short or too long, or one that does not stretch on a restart. This is visible within pulse_len cycles. A fault in edge selection shifts the sampled value by half a sample period, which changes cap_data at the next event.

// File: rtl/chgdet_pkg.sv
// Shared types for the change detection unit.
// Assumes a 2-bit per-channel mode field.
package chgdet_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_RISE = 2'b01,
        MODE_FALL = 2'b10,
        MODE_BOTH = 2'b11
    } chan_mode_e;
endpackage

// File: rtl/smp_edge_pick.sv
// Detects the selected edge of the sample clock level.
// Assumes smp_in is already synchronous to clk.
// The strobe is combinational, valid in the cycle where the new level is seen.
module smp_edge_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_in,
    input  logic use_fall,
    output logic strobe
);
    logic smp_q;

    // Remember the sample clock level from the previous core cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= 1'b0;
        else        smp_q <= smp_in;
    end

    // Pick the rising or the falling transition.
    always_comb begin
        if (use_fall) strobe = smp_q & ~smp_in;
        else          strobe = ~smp_q & smp_in;
    end

    // R5: a strobe only appears at the level the selected edge ends in.
    assert_strobe_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (use_fall ? !smp_in : smp_in));
endmodule

// File: rtl/bit_qualify_bank.sv
// Per-channel transition qualifier, laid out as ports of PORT_W bits.
// Purely combinational: it compares the previous and current samples
// under each channel's own mode.
module bit_qualify_bank
    import chgdet_pkg::*;
#(
    parameter int NCH    = 32,
    parameter int PORT_W = 8
) (
    input  logic [NCH-1:0]   prev,
    input  logic [NCH-1:0]   cur,
    input  logic [2*NCH-1:0] mode,
    output logic [NCH-1:0]   hit
);
    localparam int NPORT = NCH / PORT_W;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        for (genvar b = 0; b < PORT_W; b++) begin : g_bit
            localparam int IDX = p * PORT_W + b;
            chan_mode_e m;

            // Decode this channel's mode and judge its transition.
            always_comb begin
                m = chan_mode_e'(mode[2*IDX +: 2]);
                unique case (m)
                    MODE_RISE: hit[IDX] = ~prev[IDX] &  cur[IDX];
                    MODE_FALL: hit[IDX] =  prev[IDX] & ~cur[IDX];
                    MODE_BOTH: hit[IDX] =  prev[IDX] ^  cur[IDX];
                    default:   hit[IDX] = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/evt_pulse_gen.sv
// Event pulse stretcher.
// A load makes the output high for max(len,1) cycles,
// starting on the next cycle. A load during a pulse restarts the count.
module evt_pulse_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             pulse
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len_eff;

    // A zero width still yields a single-cycle pulse.
    always_comb len_eff = (len == '0) ? CNT_W'(1) : len;

    // Load or count down the remaining pulse cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= len_eff;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    // The pulse is high while cycles remain.
    always_comb pulse = (cnt != '0);

    // R7: a load is always followed by a high pulse.
    assert_load_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pulse);
    // R8: the pulse never ends in the cycle right after a restart.
    assert_no_drop_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse) |-> !$past(load));
endmodule

// File: rtl/change_watch.sv
// Top of the per-channel change detection unit.
// It samples din at the selected sample clock edge and compares the
// sample with the previous one under per-channel modes. On a qualifying
// change it latches the sample and the mask and starts the event pulse.
// Assumes smp_clk is synchronous to clk and that the sample period
// spans at least two core cycles.
module change_watch
    import chgdet_pkg::*;
#(
    parameter int NCH    = 32,
    parameter int PORT_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             smp_clk,
    input  logic             smp_on_fall,
    input  logic [NCH-1:0]   din,
    input  logic [2*NCH-1:0] mode_cfg,
    input  logic [CNT_W-1:0] pulse_len,
    output logic             evt_pulse,
    output logic [NCH-1:0]   cap_data,
    output logic [NCH-1:0]   cap_mask
);
    logic           strobe;
    logic           take;
    logic           prev_vld;
    logic [NCH-1:0] prev_q;
    logic [NCH-1:0] hits;
    logic           hit_any;

    smp_edge_pick u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_in   (smp_clk),
        .use_fall (smp_on_fall),
        .strobe   (strobe)
    );

    bit_qualify_bank #(.NCH(NCH), .PORT_W(PORT_W)) u_qual (
        .prev (prev_q),
        .cur  (din),
        .mode (mode_cfg),
        .hit  (hits)
    );

    // A sample is taken only at a strobe while enabled.
    always_comb take = enable & strobe;

    // An event needs a valid previous sample and at least one hit.
    always_comb hit_any = take & prev_vld & (|hits);

    // Keep the previous sample; a disable invalidates it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            prev_vld <= 1'b0;
        end else if (!enable) begin
            prev_vld <= 1'b0;
        end else if (strobe) begin
            prev_q   <= din;
            prev_vld <= 1'b1;
        end
    end

    // Latch the causing sample and its qualifying channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_data <= '0;
            cap_mask <= '0;
        end else if (hit_any) begin
            cap_data <= din;
            cap_mask <= hits;
        end
    end

    evt_pulse_gen #(.CNT_W(CNT_W)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hit_any),
        .len   (pulse_len),
        .pulse (evt_pulse)
    );

    // Channel masks decoded here, independently of the qualifier bank.
    logic [NCH-1:0] rise_sel, fall_sel, off_sel;
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            rise_sel[i] = (mode_cfg[2*i +: 2] == 2'b01);
            fall_sel[i] = (mode_cfg[2*i +: 2] == 2'b10);
            off_sel[i]  = (mode_cfg[2*i +: 2] == 2'b00);
        end
    end

    // R2: rising-mode channels only qualify when the new sample is 1.
    assert_rise_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((hits & rise_sel & ~din) == '0));
    // R3: falling-mode channels only qualify when the new sample is 0.
    assert_fall_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((hits & fall_sel & din) == '0));
    // R4: ignored channels never qualify, and unchanged channels never qualify.
    assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((hits & (off_sel | ~(prev_q ^ din))) == '0));
    // R9: after an event, the latched mask is not empty.
    assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> (cap_mask != '0));
    // R10: while disabled, the captured outputs hold.
    assert_cap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(cap_data) && $stable(cap_mask)));
endmodule

// File: tb/change_watch_test.sv
// Self-checking bench for change_watch.
// A cycle model computes the expected outputs from the requirements.
module change_watch_test;
    localparam int NCH = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            enable;
    logic            smp_clk;
    logic            smp_on_fall;
    logic [NCH-1:0]  din;
    logic [63:0]     mode_cfg;
    logic [7:0]      pulse_len;
    logic            evt_pulse;
    logic [NCH-1:0]  cap_data;
    logic [NCH-1:0]  cap_mask;

    int checks = 0;
    int fails  = 0;

    // Model state.
    logic            m_smp;
    logic            m_vld;
    logic [NCH-1:0]  m_prev;
    logic [NCH-1:0]  m_cap;
    logic [NCH-1:0]  m_mask;
    int              m_cnt;

    change_watch uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .smp_clk(smp_clk),
        .smp_on_fall(smp_on_fall), .din(din), .mode_cfg(mode_cfg),
        .pulse_len(pulse_len), .evt_pulse(evt_pulse),
        .cap_data(cap_data), .cap_mask(cap_mask)
    );

    always #5 clk = ~clk;

    // Expected set of qualifying channels.
    function automatic logic [NCH-1:0] qual(input logic [NCH-1:0] p,
            input logic [NCH-1:0] c, input logic [63:0] md);
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) begin
            case (md[2*i +: 2])
                2'b01:   r[i] = !p[i] && c[i];
                2'b10:   r[i] = p[i] && !c[i];
                2'b11:   r[i] = p[i] != c[i];
                default: r[i] = 1'b0;
            endcase
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [NCH-1:0] act,
            input logic [NCH-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Advance one core cycle with the current inputs and compare at the negedge.
    task automatic step(input string tag);
        logic [NCH-1:0] h;
        logic strobe;
        if (!rst_n) begin
            m_smp = 1'b0; m_vld = 1'b0; m_prev = '0;
            m_cap = '0; m_mask = '0; m_cnt = 0;
        end else begin
            strobe = smp_on_fall ? (m_smp && !smp_clk) : (!m_smp && smp_clk);
            if (!enable) begin
                m_vld = 1'b0;
                if (m_cnt > 0) m_cnt--;
            end else if (strobe) begin
                h = qual(m_prev, din, mode_cfg);
                if (m_vld && h != '0) begin
                    m_cap = din; m_mask = h;
                    m_cnt = (pulse_len == 0) ? 1 : int'(pulse_len);
                end else if (m_cnt > 0) m_cnt--;
                m_prev = din; m_vld = 1'b1;
            end else if (m_cnt > 0) m_cnt--;
            m_smp = smp_clk;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, {31'd0, evt_pulse}, {31'd0, m_cnt != 0}, "evt_pulse");
        check(tag, cap_data, m_cap, "cap_data");
        check(tag, cap_mask, m_mask, "cap_mask");
    endtask

    // One full sample period: active level then idle level.
    task automatic sample(input logic [NCH-1:0] d, input string tag);
        din = d;
        smp_clk = !smp_on_fall;
        step(tag);
        smp_clk = smp_on_fall;
        step(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; enable = 1'b0; smp_clk = 1'b0; smp_on_fall = 1'b0;
        din = '0; mode_cfg = '0; pulse_len = 8'd3;
        @(negedge clk);
        idle(3, "R1");
        rst_n = 1'b1;
        check("R1", {31'd0, evt_pulse}, 32'd0, "reset evt_pulse");
        check("R1", cap_data, '0, "reset cap_data");
        check("R1", cap_mask, '0, "reset cap_mask");

        // R6: the first sample after enable never raises an event.
        mode_cfg = {32{2'b11}};
        enable = 1'b1;
        sample(32'hFFFF_FFFF, "R6");
        check("R6", {31'd0, evt_pulse}, 32'd0, "first sample evt");
        idle(2, "R6");

        // R2: rising-only channels.
        mode_cfg = {32{2'b01}};
        sample(32'h0000_0000, "R2");
        idle(4, "R2");
        sample(32'hFFFF_0000, "R2");
        check("R2", cap_mask, 32'hFFFF_0000, "rise mask");
        idle(4, "R2");
        sample(32'h0000_0000, "R2");
        idle(4, "R2");

        // R3: falling-only channels.
        mode_cfg = {32{2'b10}};
        sample(32'h00FF_00FF, "R3");
        idle(4, "R3");
        sample(32'h0000_0000, "R3");
        check("R3", cap_mask, 32'h00FF_00FF, "fall mask");
        idle(4, "R3");

        // R4: per-port modes: port0 ignore, port1 rise, port2 fall, port3 either.
        mode_cfg = {{8{2'b11}}, {8{2'b10}}, {8{2'b01}}, {8{2'b00}}};
        sample(32'h00FF_0000, "R4");
        idle(4, "R4");
        sample(32'hFF00_FFFF, "R4");
        check("R4", cap_mask, 32'hFFFF_FF00, "mixed mask");
        idle(4, "R4");
        sample(32'hFF00_FF00, "R4");
        idle(4, "R4");

        // R5: falling-edge sampling; a value present between samples is unseen.
        mode_cfg = {32{2'b11}};
        smp_on_fall = 1'b1;
        smp_clk = 1'b0;
        idle(2, "R5");
        sample(32'h1234_5678, "R5");
        idle(3, "R5");
        din = 32'hFFFF_FFFF;
        idle(2, "R5");
        sample(32'h1234_5678, "R5");
        idle(3, "R5");
        smp_on_fall = 1'b0;
        smp_clk = 1'b0;
        idle(2, "R5");

        // R7: pulse widths, including zero.
        pulse_len = 8'd0;
        sample(32'hA5A5_A5A5, "R7");
        idle(3, "R7");
        pulse_len = 8'd5;
        sample(32'h5A5A_5A5A, "R7");
        idle(6, "R7");

        // R8: back-to-back changes restart the count.
        pulse_len = 8'd6;
        for (int i = 0; i < 5; i++) sample(32'h1 << i, "R8");
        idle(8, "R8");

        // R10: while disabled nothing is sampled.
        enable = 1'b0;
        for (int i = 0; i < 4; i++) sample($urandom, "R10");
        idle(2, "R10");
        enable = 1'b1;
        sample(32'hDEAD_BEEF, "R10");
        idle(2, "R10");

        // R9: random modes, data, sample timing, widths and enable.
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 64) == 0) mode_cfg = {$urandom, $urandom};
            if (($urandom % 100) == 0) pulse_len = 8'($urandom % 9);
            if (($urandom % 200) == 0) enable = !enable;
            if (($urandom % 300) == 0) smp_on_fall = !smp_on_fall;
            if (($urandom % 3) == 0) smp_clk = !smp_clk;
            din = (($urandom % 4) == 0) ? $urandom : din ^ (32'h1 << ($urandom % 32));
            step("R9");
        end
        enable = 1'b1;
        idle(10, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule